// File: doc/BRIEF.md
# Pin Interrupt and Direction Controller

This block manages thirty-two general-purpose pins behind a halfword-wide register port. Each pin can be an input or an output. Every input can be set up to flag an interrupt condition, either as a level or as an edge. The per-pin flags are gated by a mask and reduced to one interrupt line for the processor. Software finds the cause by reading the status halves and acknowledges it by writing ones back.

Every per-pin setting lives in a pair of 16-bit registers. The lower register of a pair covers pins 0 to 15. The upper register covers pins 16 to 31, with pin n at bit n-16. The register port is addressed by a halfword index, which is the byte offset divided by two. Writes take effect on the clock edge at which `we` is high. Reads are combinational from `reg_sel`.

Each input passes through two flip-flops before any detection. An edge is found by comparing the synchronized value with its sample from the previous cycle.

Top module: `gpio_irq_unit`

## Requirements
- R1: Register map by halfword index (low half, then high half):
  - direction 0/1
  - pin data 2/3
  - status 4/5
  - mask 6/7
  - kind (1 = edge, 0 = level) 8/9
  - polarity (1 = active high, 0 = active low) 10/11
  - latch (1 = hold) 12/13
  - falling-edge enable 16/17
  - rising-edge enable 18/19

  Every configuration register reads back what was written. Any other index reads 0, and writes to it change nothing.
- R2: `pin_oe` equals the direction bits. `pin_out` equals the pin-data register ANDed with the direction bits. Both change on the edge that takes the write.
- R3: A pin-data read returns the stored output bit for output pins and the synchronized input for input pins. An input change is visible two clock edges after it is applied.
- R4: In level mode the status bit follows the synchronized input on every cycle (no latching). Polarity 1 flags a high pin; polarity 0 flags a low pin. A write-1 clear has no lasting effect while the level persists.
- R5: In edge mode with latch 1, a qualifying edge sets the status bit. The bit then stays set until software clears it.
- R6: In edge mode with latch 0, the status bit is high for exactly the one cycle after the edge is seen.
- R7: In edge mode a rise counts only when its rising enable is 1, and a fall counts only when its falling enable is 1. With both enables set, either edge counts; with neither set, no edge counts.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: When a clear and a new qualifying edge reach a status bit on the same edge, the status bit ends up set.
- R10: `irq` is high exactly when some status bit and its mask bit are both 1, in either half.
- R11: Reset sets direction, data, mask, kind, polarity, latch, both edge enables and status to 0. This leaves all pins as inputs with `irq` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Register write strobe |
| reg_sel | input | 5 | Halfword register index |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `reg_sel` |
| pin_in | input | 32 | Asynchronous pin inputs |
| pin_out | output | 32 | Output values |
| pin_oe | output | 32 | Output enables |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions check these relations on every cycle:
- direction writes reach `pin_oe` one edge later;
- latched edge flags never drop without a write;
- level flags track the selected polarity of the synchronized input;
- pass-through edge flags fall when no edge is seen;
- cleared edge flags fall when the input is quiet;
- `irq` stays low under a zero mask.

Only the bench scenarios show the rest:
- which edge directions count for each enable setting;
- that a new edge wins over a clear arriving in the same cycle;
- the two-edge input delay;
- the exact bit position of an upper-half pin.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int SEL_W = 5;

    // Halfword index of each register; bit 0 picks the half.
    typedef enum logic [SEL_W-1:0] {
        SEL_DIR_LO = 5'd0,
        SEL_DIR_HI = 5'd1,
        SEL_DAT_LO = 5'd2,
        SEL_DAT_HI = 5'd3,
        SEL_STA_LO = 5'd4,
        SEL_STA_HI = 5'd5,
        SEL_ENA_LO = 5'd6,
        SEL_ENA_HI = 5'd7,
        SEL_TYP_LO = 5'd8,
        SEL_TYP_HI = 5'd9,
        SEL_LVL_LO = 5'd10,
        SEL_LVL_HI = 5'd11,
        SEL_HLD_LO = 5'd12,
        SEL_HLD_HI = 5'd13,
        SEL_FAL_LO = 5'd16,
        SEL_FAL_HI = 5'd17,
        SEL_RIS_LO = 5'd18,
        SEL_RIS_HI = 5'd19
    } reg_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_raw,
    output logic [W-1:0] pin_now,
    output logic [W-1:0] pin_last
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] now;
        logic [W-1:0] last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = pin_raw;
        sync_d.now  = sync_q.meta;
        sync_d.last = sync_q.now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign pin_now  = sync_q.now;
    assign pin_last = sync_q.last;

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [SEL_W-1:0]      reg_sel,
    input  logic [HALF_W-1:0]     wdata,
    output logic [2*HALF_W-1:0]   dir,
    output logic [2*HALF_W-1:0]   dout,
    output logic [2*HALF_W-1:0]   en,
    output logic [2*HALF_W-1:0]   etyp,
    output logic [2*HALF_W-1:0]   alv,
    output logic [2*HALF_W-1:0]   hold,
    output logic [2*HALF_W-1:0]   fen,
    output logic [2*HALF_W-1:0]   ren
);

    localparam int NPINS = 2 * HALF_W;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] etyp;
        logic [NPINS-1:0] alv;
        logic [NPINS-1:0] hold;
        logic [NPINS-1:0] fen;
        logic [NPINS-1:0] ren;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    function automatic logic [NPINS-1:0] put_half(
        input logic [NPINS-1:0]  old_v,
        input logic              upper,
        input logic [HALF_W-1:0] val
    );
        logic [NPINS-1:0] r;
        r = old_v;
        if (upper) begin
            r[NPINS-1:HALF_W] = val;
        end else begin
            r[HALF_W-1:0] = val;
        end
        return r;
    endfunction

    logic upper;
    assign upper = reg_sel[0];

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (reg_sel)
                SEL_DIR_LO, SEL_DIR_HI: cfg_d.dir  = put_half(cfg_q.dir,  upper, wdata);
                SEL_DAT_LO, SEL_DAT_HI: cfg_d.dout = put_half(cfg_q.dout, upper, wdata);
                SEL_ENA_LO, SEL_ENA_HI: cfg_d.en   = put_half(cfg_q.en,   upper, wdata);
                SEL_TYP_LO, SEL_TYP_HI: cfg_d.etyp = put_half(cfg_q.etyp, upper, wdata);
                SEL_LVL_LO, SEL_LVL_HI: cfg_d.alv  = put_half(cfg_q.alv,  upper, wdata);
                SEL_HLD_LO, SEL_HLD_HI: cfg_d.hold = put_half(cfg_q.hold, upper, wdata);
                SEL_FAL_LO, SEL_FAL_HI: cfg_d.fen  = put_half(cfg_q.fen,  upper, wdata);
                SEL_RIS_LO, SEL_RIS_HI: cfg_d.ren  = put_half(cfg_q.ren,  upper, wdata);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dir  = cfg_q.dir;
    assign dout = cfg_q.dout;
    assign en   = cfg_q.en;
    assign etyp = cfg_q.etyp;
    assign alv  = cfg_q.alv;
    assign hold = cfg_q.hold;
    assign fen  = cfg_q.fen;
    assign ren  = cfg_q.ren;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_now,
    input  logic [W-1:0] pin_last,
    input  logic [W-1:0] etyp,
    input  logic [W-1:0] alv,
    input  logic [W-1:0] hold,
    input  logic [W-1:0] fen,
    input  logic [W-1:0] ren,
    input  logic [W-1:0] clr,
    output logic [W-1:0] status
);

    typedef struct packed {
        logic [W-1:0] flag;
    } det_t;

    det_t det_d, det_q;

    logic [W-1:0] edge_hit;
    logic [W-1:0] level_hit;
    logic [W-1:0] keep;

    // One lane per pin; each lane picks level or edge from its kind bit.
    for (genvar i = 0; i < W; i++) begin : g_lane
        logic rise_i, fall_i;
        assign rise_i       = pin_now[i] & ~pin_last[i];
        assign fall_i       = ~pin_now[i] & pin_last[i];
        assign edge_hit[i]  = (rise_i & ren[i]) | (fall_i & fen[i]);
        assign level_hit[i] = ~(pin_now[i] ^ alv[i]);
        assign keep[i]      = etyp[i] & hold[i] & det_q.flag[i] & ~clr[i];
    end

    always_comb begin
        det_d      = det_q;
        // A fresh hit always wins over a clear of the same bit.
        det_d.flag = ((etyp & edge_hit) | (~etyp & level_hit)) | keep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign status = det_q.flag;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [SEL_W-1:0]     reg_sel,
    input  logic [HALF_W-1:0]    wdata,
    output logic [HALF_W-1:0]    rdata,
    input  logic [2*HALF_W-1:0]  pin_in,
    output logic [2*HALF_W-1:0]  pin_out,
    output logic [2*HALF_W-1:0]  pin_oe,
    output logic                 irq
);

    localparam int NPINS = 2 * HALF_W;

    logic [NPINS-1:0] sync_in, prev_in;
    logic [NPINS-1:0] cfg_dir, cfg_dout, cfg_en, cfg_etyp;
    logic [NPINS-1:0] cfg_alv, cfg_hold, cfg_fen, cfg_ren;
    logic [NPINS-1:0] status, clr_mask, dat_view;

    gpio_pin_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in),
        .pin_now  (sync_in),
        .pin_last (prev_in)
    );

    gpio_cfg_regs #(.HALF_W(HALF_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .reg_sel (reg_sel),
        .wdata   (wdata),
        .dir     (cfg_dir),
        .dout    (cfg_dout),
        .en      (cfg_en),
        .etyp    (cfg_etyp),
        .alv     (cfg_alv),
        .hold    (cfg_hold),
        .fen     (cfg_fen),
        .ren     (cfg_ren)
    );

    always_comb begin
        clr_mask = '0;
        if (we && reg_sel == SEL_STA_LO) begin
            clr_mask[HALF_W-1:0] = wdata;
        end else if (we && reg_sel == SEL_STA_HI) begin
            clr_mask[NPINS-1:HALF_W] = wdata;
        end
    end

    gpio_irq_detect #(.W(NPINS)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_now  (sync_in),
        .pin_last (prev_in),
        .etyp     (cfg_etyp),
        .alv      (cfg_alv),
        .hold     (cfg_hold),
        .fen      (cfg_fen),
        .ren      (cfg_ren),
        .clr      (clr_mask),
        .status   (status)
    );

    assign dat_view = (cfg_dout & cfg_dir) | (sync_in & ~cfg_dir);
    assign pin_oe   = cfg_dir;
    assign pin_out  = cfg_dout & cfg_dir;
    assign irq      = |(status & cfg_en);

    function automatic logic [HALF_W-1:0] pick(
        input logic [NPINS-1:0] v,
        input logic             upper
    );
        return upper ? v[NPINS-1:HALF_W] : v[HALF_W-1:0];
    endfunction

    always_comb begin
        case (reg_sel)
            SEL_DIR_LO, SEL_DIR_HI: rdata = pick(cfg_dir,  reg_sel[0]);
            SEL_DAT_LO, SEL_DAT_HI: rdata = pick(dat_view, reg_sel[0]);
            SEL_STA_LO, SEL_STA_HI: rdata = pick(status,   reg_sel[0]);
            SEL_ENA_LO, SEL_ENA_HI: rdata = pick(cfg_en,   reg_sel[0]);
            SEL_TYP_LO, SEL_TYP_HI: rdata = pick(cfg_etyp, reg_sel[0]);
            SEL_LVL_LO, SEL_LVL_HI: rdata = pick(cfg_alv,  reg_sel[0]);
            SEL_HLD_LO, SEL_HLD_HI: rdata = pick(cfg_hold, reg_sel[0]);
            SEL_FAL_LO, SEL_FAL_HI: rdata = pick(cfg_fen,  reg_sel[0]);
            SEL_RIS_LO, SEL_RIS_HI: rdata = pick(cfg_ren,  reg_sel[0]);
            default:                rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
    import gpio_irq_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                we,
    input logic [SEL_W-1:0]    sel,
    input logic [HALF_W-1:0]   wdata,
    input logic                irq,
    input logic [2*HALF_W-1:0] pin_oe,
    input logic [2*HALF_W-1:0] status,
    input logic [2*HALF_W-1:0] en,
    input logic [2*HALF_W-1:0] etyp,
    input logic [2*HALF_W-1:0] alv,
    input logic [2*HALF_W-1:0] hold,
    input logic [2*HALF_W-1:0] sync_in,
    input logic [2*HALF_W-1:0] prev_in
);

    localparam int NPINS = 2 * HALF_W;

    logic [NPINS-1:0] wr_clear;
    logic [NPINS-1:0] quiet;
    logic [NPINS-1:0] held;
    logic [NPINS-1:0] want_level;

    always_comb begin
        wr_clear = '0;
        if (we && sel == SEL_STA_LO) wr_clear[HALF_W-1:0]     = wdata;
        if (we && sel == SEL_STA_HI) wr_clear[NPINS-1:HALF_W] = wdata;
    end

    assign quiet      = ~(sync_in ^ prev_in);
    assign held       = status & etyp & hold;
    assign want_level = ~(sync_in ^ alv) & ~etyp;

    AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_DIR_LO) |=> (pin_oe[HALF_W-1:0] == $past(wdata))); // R2

    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (!we) |=> ((status & $past(held)) == $past(held))); // R5

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (!we) |=> ((status & $past(~etyp)) == $past(want_level))); // R4

    AST_THROUGH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(etyp & ~hold)) |=> ((status & $past(etyp & ~hold & quiet)) == '0)); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_clear) |=> ((status & $past(wr_clear & etyp & quiet)) == '0)); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq); // R10

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.HALF_W(HALF_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (we),
    .sel     (reg_sel),
    .wdata   (wdata),
    .irq     (irq),
    .pin_oe  (pin_oe),
    .status  (status),
    .en      (cfg_en),
    .etyp    (cfg_etyp),
    .alv     (cfg_alv),
    .hold    (cfg_hold),
    .sync_in (sync_in),
    .prev_in (prev_in)
);

// File: tb/gpio_irq_unit_test.sv
`timescale 1ns/1ps
module gpio_irq_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  reg_sel = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [4:0] DIR_LO = 5'd0,  DIR_HI = 5'd1,  DAT_HI = 5'd3;
    localparam logic [4:0] STA_LO = 5'd4,  STA_HI = 5'd5;
    localparam logic [4:0] ENA_LO = 5'd6,  ENA_HI = 5'd7,  TYP_LO = 5'd8;

    // {index, write value, expected readback}
    localparam int NTAB = 16;
    localparam logic [36:0] TAB [NTAB] = '{
        {5'd8,  16'h001F, 16'h001F},
        {5'd12, 16'h000F, 16'h000F},
        {5'd18, 16'h0015, 16'h0015},
        {5'd16, 16'h0006, 16'h0006},
        {5'd10, 16'hFDFF, 16'hFDFF},
        {5'd9,  16'h0001, 16'h0001},
        {5'd13, 16'h0001, 16'h0001},
        {5'd19, 16'h0001, 16'h0001},
        {5'd17, 16'h0000, 16'h0000},
        {5'd11, 16'hFFFF, 16'hFFFF},
        {5'd1,  16'hF000, 16'hF000},
        {5'd0,  16'h0000, 16'h0000},
        {5'd6,  16'h8000, 16'h8000},
        {5'd7,  16'h0000, 16'h0000},
        {5'd14, 16'h1234, 16'h0000},
        {5'd15, 16'hFFFF, 16'h0000}
    };

    gpio_irq_unit uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .reg_sel (reg_sel),
        .wdata   (wdata),
        .rdata   (rdata),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq     (irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_sel = s;
        wdata   = d;
        we      = 1'b1;
        @(negedge clk);
        we      = 1'b0;
    endtask

    task automatic rd(input logic [4:0] s, output logic [15:0] d);
        reg_sel = s;
        #1;
        d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_set(input int idx, input logic v);
        @(negedge clk);
        pin_in[idx] = v;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;

        // Reset state (R11)
        settle(3);
        chk("R11 irq", {31'b0, irq}, 32'h0);
        chk("R11 pin_oe", pin_oe, 32'h0);
        rd(DIR_LO, v); chk("R11 dir", {16'h0, v}, 32'h0);
        rd(ENA_LO, v); chk("R11 mask", {16'h0, v}, 32'h0);
        rd(TYP_LO, v); chk("R11 kind", {16'h0, v}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // Register map walk (R1)
        for (int i = 0; i < NTAB; i++) begin
            wr(TAB[i][36:32], TAB[i][31:16]);
            rd(TAB[i][36:32], v);
            chk("R1 readback", {16'h0, v}, {16'h0, TAB[i][15:0]});
        end

        settle(2);
        wr(STA_LO, 16'hFFFF);
        wr(STA_HI, 16'hFFFF);
        settle(1);
        rd(STA_LO, v); chk("R4 active-low level", {16'h0, v}, 32'h0200);
        rd(STA_HI, v); chk("R4 high idle", {16'h0, v}, 32'h0);
        chk("R10 masked", {31'b0, irq}, 32'h0);

        // Rising-only pin 0, latched (R7, R5, R8)
        pin_set(0, 1'b1); settle(3);
        rd(STA_LO, v); chk("R7 rise", {16'h0, v & 16'h001F}, 32'h1);
        settle(5);
        rd(STA_LO, v); chk("R5 held", {16'h0, v & 16'h001F}, 32'h1);
        wr(STA_LO, 16'h0000);
        rd(STA_LO, v); chk("R8 zero write", {16'h0, v & 16'h001F}, 32'h1);
        wr(STA_LO, 16'h0001);
        rd(STA_LO, v); chk("R8 clear", {16'h0, v & 16'h001F}, 32'h0);
        pin_set(0, 1'b0); settle(3);
        rd(STA_LO, v); chk("R7 fall ignored", {16'h0, v & 16'h001F}, 32'h0);

        // Falling-only pin 1 (R7)
        pin_set(1, 1'b1); settle(3);
        rd(STA_LO, v); chk("R7 rise ignored", {16'h0, v & 16'h001F}, 32'h0);
        pin_set(1, 1'b0); settle(3);
        rd(STA_LO, v); chk("R7 fall", {16'h0, v & 16'h001F}, 32'h2);
        wr(STA_LO, 16'h0002);

        // Both edges pin 2 (R7)
        pin_set(2, 1'b1); settle(3);
        rd(STA_LO, v); chk("R7 both rise", {16'h0, v & 16'h001F}, 32'h4);
        wr(STA_LO, 16'h0004);
        pin_set(2, 1'b0); settle(3);
        rd(STA_LO, v); chk("R7 both fall", {16'h0, v & 16'h001F}, 32'h4);
        wr(STA_LO, 16'h0004);

        // No edges enabled pin 3 (R7)
        pin_set(3, 1'b1); settle(3);
        rd(STA_LO, v); chk("R7 none rise", {16'h0, v & 16'h001F}, 32'h0);
        pin_set(3, 1'b0); settle(3);
        rd(STA_LO, v); chk("R7 none fall", {16'h0, v & 16'h001F}, 32'h0);

        // Pass-through edge pin 4 (R6)
        pin_set(4, 1'b1); settle(3);
        rd(STA_LO, v); chk("R6 pulse", {16'h0, v & 16'h0010}, 32'h10);
        settle(1);
        rd(STA_LO, v); chk("R6 pulse ends", {16'h0, v & 16'h0010}, 32'h0);

        // Level pins 8 (high) and 9 (low) (R4)
        pin_set(8, 1'b1); settle(3);
        rd(STA_LO, v); chk("R4 active high", {16'h0, v & 16'h0300}, 32'h0300);
        pin_set(8, 1'b0); settle(3);
        rd(STA_LO, v); chk("R4 follows", {16'h0, v & 16'h0300}, 32'h0200);
        wr(STA_LO, 16'h0200);
        rd(STA_LO, v); chk("R4 clear no effect", {16'h0, v & 16'h0200}, 32'h0200);
        pin_set(9, 1'b1); settle(3);
        rd(STA_LO, v); chk("R4 low released", {16'h0, v & 16'h0200}, 32'h0);

        // Event beats clear in the same cycle (R9)
        pin_set(0, 1'b1); settle(3);
        pin_set(0, 1'b0); settle(3);
        rd(STA_LO, v); chk("R9 setup", {16'h0, v & 16'h0001}, 32'h1);
        @(negedge clk); pin_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); reg_sel = STA_LO; wdata = 16'h0001; we = 1'b1;
        @(negedge clk); we = 1'b0;
        rd(STA_LO, v); chk("R9 event wins", {16'h0, v & 16'h0001}, 32'h1);
        wr(STA_LO, 16'h0001);
        rd(STA_LO, v); chk("R9 later clear", {16'h0, v & 16'h0001}, 32'h0);

        // Combined interrupt (R10)
        wr(ENA_LO, 16'h0001);
        chk("R10 no status", {31'b0, irq}, 32'h0);
        pin_set(0, 1'b0); pin_set(0, 1'b1); settle(3);
        chk("R10 low half", {31'b0, irq}, 32'h1);
        wr(STA_LO, 16'h0001);
        chk("R10 cleared", {31'b0, irq}, 32'h0);
        wr(ENA_HI, 16'h0001);
        pin_set(16, 1'b1); settle(3);
        rd(STA_HI, v); chk("R1 upper bit position", {16'h0, v}, 32'h0001);
        chk("R10 high half", {31'b0, irq}, 32'h1);
        wr(STA_HI, 16'h0001);
        chk("R10 high cleared", {31'b0, irq}, 32'h0);

        // Outputs and pin data readback (R2, R3)
        wr(DAT_HI, 16'hA002);
        chk("R2 oe", pin_oe, 32'hF000_0000);
        chk("R2 out", pin_out, 32'hA000_0000);
        rd(DAT_HI, v); chk("R3 mixed read", {16'h0, v}, 32'hA001);
        @(negedge clk); pin_in[20] = 1'b1;
        @(negedge clk);
        rd(DAT_HI, v); chk("R3 one edge", {16'h0, v & 16'h0010}, 32'h0);
        @(negedge clk);
        rd(DAT_HI, v); chk("R3 two edges", {16'h0, v & 16'h0010}, 32'h10);
        wr(DIR_HI, 16'h0000);
        chk("R2 oe off", pin_oe, 32'h0);

        finish_run();
    end

endmodule